// File: doc/BRIEF.md
# Age-Counter Replacement Victim Selector

This block holds the replacement state of a four-way, 256-set cache. Each way of each set has a two-bit age. A use of a line clears that way's age. The same use raises the age of every other way in its set by one, and an age that is already at its ceiling stays there. Tags and line data are kept elsewhere. The surrounding cache controller reports each use of a line as a touch, made up of a valid strobe, a set index and a way number.

On a miss, the controller presents a set index on the query port. The block answers in the same cycle with the way to evict, which is a way holding the oldest age in that set. When several ways share the oldest age, the block picks one of them using a free-running 16-bit linear feedback shift register. The two low bits of the register give the starting way, and the block scans forward from there, wrapping round, until it reaches a tied way.

Top module: `lru_age_victim`

## Requirements
- R1: After reset every age in every set is zero, so all four ways of a set are tied.
- R2: A touch sets the touched way's age to zero at the next rising clock edge.
- R3: A touch adds one to the age of each of the other three ways in the same set at the same edge.
- R4: An age of 3 that is raised again stays at 3 and never wraps to 0.
- R5: A touch changes no age in any set other than its own.
- R6: The victim output is always a way whose age is the largest in the queried set. When exactly one way holds that age, the victim is that way.
- R7: When several ways share the largest age, the victim is one of the tied ways.
- R8: The choice among tied ways changes over time, so a fully tied set presents every way as victim within 64 cycles.
- R9: The victim follows the query set index in the same cycle, with no clock edge in between.
- R10: A touch and a query to the same set in one cycle return the victim from the ages held before that touch.
- R11: While touch_valid is low, the touch set and way inputs change no age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_valid | input | 1 | A touch is present this cycle |
| touch_set | input | 8 | Set index of the touch |
| touch_way | input | 2 | Way number of the touch |
| query_set | input | 8 | Set index whose victim is wanted |
| victim_way | output | 2 | Way to evict from query_set |

## Verification
The assertions assume that the touch way is always a legal way number and that the set inputs are known whenever they are sampled. The assertions on ages are sampled one edge after a touch, so they also assume the reset is synchronous and held for at least one edge. The stimulus drives every input at the falling edge, starting in the cycle that follows reset release, and keeps those inputs stable through the next rising edge. It uses only way numbers 0 to 3 and set indices within 0 to 255. The bench holds its own model of the ages, built from the requirements, and accepts any tied way as a correct victim.

// File: rtl/lru_age_victim.sv
module lru_age_victim #(
  parameter int NUM_WAYS  = 4,
  parameter int NUM_SETS  = 256,
  parameter int AGE_W     = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        touch_valid,
  input  logic [$clog2(NUM_SETS)-1:0] touch_set,
  input  logic [$clog2(NUM_WAYS)-1:0] touch_way,
  input  logic [$clog2(NUM_SETS)-1:0] query_set,
  output logic [$clog2(NUM_WAYS)-1:0] victim_way
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [AGE_W-1:0] age_q [NUM_SETS][NUM_WAYS];
  logic [15:0]      lfsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= '0;
    end else if (touch_valid) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] != AGE_MAX)
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  wire lfsr_fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= {lfsr_q[14:0], lfsr_fb};
  end

  logic [AGE_W-1:0] q_age [NUM_WAYS];
  logic [AGE_W-1:0] max_age;
  logic [NUM_WAYS-1:0] tied;
  logic [WAY_W-1:0] scan_start, scan_idx;
  logic found;

  assign scan_start = lfsr_q[WAY_W-1:0];

  always_comb begin
    max_age = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      q_age[w] = age_q[query_set][w];
      if (q_age[w] > max_age) max_age = q_age[w];
    end
    for (int w = 0; w < NUM_WAYS; w++)
      tied[w] = (q_age[w] == max_age);
    victim_way = scan_start;
    found = 1'b0;
    scan_idx = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      scan_idx = scan_start + WAY_W'(i);
      if (!found && tied[scan_idx]) begin
        victim_way = scan_idx;
        found = 1'b1;
      end
    end
  end

  logic             prev_v;
  logic [SET_W-1:0] prev_set;
  logic [WAY_W-1:0] prev_way;
  logic [AGE_W-1:0] prev_age [NUM_WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_v <= 1'b0;
    else        prev_v <= touch_valid;
    prev_set <= touch_set;
    prev_way <= touch_way;
    for (int w = 0; w < NUM_WAYS; w++)
      prev_age[w] <= age_q[touch_set][w];
  end

  // R2
  touch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_v |-> age_q[prev_set][prev_way] == '0);

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_chk
    // R3 R4
    others_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_v && prev_way != WAY_W'(g)) |->
        age_q[prev_set][g] == ((prev_age[g] == AGE_MAX) ? AGE_MAX : AGE_W'(prev_age[g] + 1'b1)));
    // R6 R7
    victim_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      age_q[query_set][victim_way] >= age_q[query_set][g]);
  end
endmodule

// File: tb/lru_age_victim_test.sv
`timescale 1ns/1ps
module lru_age_victim_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic touch_valid = 1'b0;
  logic [7:0] touch_set = '0;
  logic [1:0] touch_way = '0;
  logic [7:0] query_set = '0;
  logic [1:0] victim_way;

  always #4 clk = ~clk;

  lru_age_victim uut (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_set(touch_set),
    .touch_way(touch_way), .query_set(query_set), .victim_way(victim_way)
  );

  int compared = 0;
  int mismatched = 0;
  int ages [256][4];
  logic [3:0] exp_q [$];
  string tag_q [$];
  logic [3:0] seen_r8 = '0;
  int cycles = 0;
  bit done = 0;

  function automatic logic [3:0] allowed(input int s);
    int mx = 0;
    logic [3:0] m;
    for (int w = 0; w < 4; w++) if (ages[s][w] > mx) mx = ages[s][w];
    for (int w = 0; w < 4; w++) m[w] = (ages[s][w] == mx);
    return m;
  endfunction

  task automatic step(input bit tv, input int ts, input int tw, input int qs, input string tag);
    @(negedge clk);
    touch_valid = tv;
    touch_set = 8'(ts);
    touch_way = 2'(tw);
    query_set = 8'(qs);
    exp_q.push_back(allowed(qs));
    tag_q.push_back(tag);
    if (tv)
      for (int w = 0; w < 4; w++)
        if (w == tw) ages[ts][w] = 0;
        else if (ages[ts][w] < 3) ages[ts][w]++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [3:0] m;
        string t;
        m = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (t == "R8") seen_r8[victim_way] = 1'b1;
        if (!m[victim_way]) begin
          mismatched++;
          $display("FAIL %s: victim %0d, expected one of mask %b", t, victim_way, m);
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    for (int s = 0; s < 256; s++) for (int w = 0; w < 4; w++) ages[s][w] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: fresh sets at both ends tied
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 255, "R1");
    // R10: touch and query same set, pre-update ages
    step(1, 5, 0, 5, "R10");
    // R1 R2 R3: only way 0 cleared, others now 1
    step(0, 0, 0, 5, "R3");
    step(1, 5, 1, 5, "R10");
    step(0, 0, 0, 5, "R2");
    step(1, 5, 2, 5, "R3");
    step(0, 0, 0, 5, "R6");
    // R4: saturate at 3
    step(1, 5, 2, 5, "R4");
    step(1, 5, 2, 5, "R4");
    step(1, 5, 2, 5, "R4");
    step(0, 0, 0, 5, "R4");
    step(1, 5, 3, 5, "R7");
    step(1, 5, 0, 5, "R7");
    step(0, 0, 0, 5, "R6");
    // Unique oldest in set 9
    for (int w = 0; w < 4; w++) step(1, 9, w, 9, "R6");
    step(0, 0, 0, 9, "R6");
    // R5: other-set touches leave set 9 alone
    for (int i = 0; i < 6; i++) step(1, 10, i % 4, 9, "R5");
    step(1, 255, 3, 9, "R5");
    step(0, 0, 0, 255, "R3");
    // R11: invalid touch ignored
    for (int i = 0; i < 4; i++) step(0, 9, 0, 9, "R11");
    // R9: query follows set in the same cycle
    for (int i = 0; i < 6; i++) step(0, 0, 0, (i % 2) ? 5 : 9, "R9");
    // R8: ties spread over all ways
    for (int i = 0; i < 64; i++) step(0, 0, 0, 200, "R8");
    @(negedge clk);
    #3;
    compared++;
    if (seen_r8 != 4'hF) begin
      mismatched++;
      $display("FAIL R8: ways seen %b, expected %b", seen_r8, 4'hF);
    end
    done = 1;
    finish_run();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: cycles %0d, expected under %0d", cycles, 20000);
      finish_run();
    end
  end
endmodule